// File: doc/BRIEF.md
# USB Host Controller Functional-State Register

This block holds the functional state of a USB host controller built on the open host interface model, together with the small set of control bits that go with it. The host driver writes and reads a 2-bit state field, a remote-wakeup enable, a remote-wakeup-connected flag and an interrupt-routing bit through one 5-bit word. The block separates a hardware reset (asynchronous, active low), which lands the controller in the reset state, from a software reset (a synchronous pulse), which lands it in suspend. A hardware reset also clears the wakeup-connected flag; a software reset leaves it alone.

While in suspend the block moves itself to resume when a downstream port reports resume signaling. It changes the state field on its own in no other state. Each time the state enters operational, a cycle counter of one millisecond starts. When it expires, start-of-frame generation is enabled and a one-cycle started pulse is given. Leaving operational early abandons the count.

The block also raises a remote-wakeup request toward the system when wakeup is enabled and the resume-detected status is present. It holds root-hub reset signaling toward the downstream ports while the state is reset, which includes the time after a hardware reset.

Top module: `usb_hc_fstate`

## Requirements
- R1: While `rstN` is low and after it rises, `rdData` reads 0 (state reset, all control bits 0) and `sofEnable`, `sofStarted` are 0.
- R2: The word layout on `wrData` and `rdData` is bit[1:0] state (00 reset, 01 resume, 10 operational, 11 suspend), bit 2 routing, bit 3 wakeup enable, bit 4 wakeup connected. A write with `wrEn` shows on `rdData` one cycle later.
- R3: A `swReset` pulse sets the state to suspend (11) and clears wakeup enable and routing one cycle later. Wakeup connected keeps its value. `swReset` wins over a write in the same cycle.
- R4: In suspend, `portResume` moves the state to resume (01) one cycle later. In any other state `portResume` leaves the state unchanged. A write in the same cycle wins over `portResume`.
- R5: `sofEnable` rises exactly CYCLES_PER_MS cycles after `rdData` first shows operational, then stays high while the state remains operational. Rewriting operational while already operational does not restart the delay.
- R6: `sofEnable` is low in every cycle in which the state is not operational. A departure from operational before the delay ends discards the count, and the next entry waits the full CYCLES_PER_MS cycles again.
- R7: `sofStarted` is high for exactly one cycle, the cycle in which `sofEnable` first reads high after an entry into operational.
- R8: `wakeReq` equals wakeup enable AND `resumeFlag` in the same cycle.
- R9: `rootHubReset` is high exactly when the state field reads reset (00).
- R10: The routing bit is stored and read back but changes no other output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hardware reset, asynchronous, active low |
| swReset | input | 1 | Software reset pulse |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 5 | Control word to write |
| portResume | input | 1 | Resume signaling seen on a downstream port |
| resumeFlag | input | 1 | Resume-detected status flag |
| rdData | output | 5 | Current control word |
| sofEnable | output | 1 | Start-of-frame generation enabled |
| sofStarted | output | 1 | One-cycle pulse on the first enabled frame |
| wakeReq | output | 1 | Remote-wakeup request to the system |
| rootHubReset | output | 1 | Reset signaling toward the root hub and downstream ports |

## Verification
Writes, software resets and port resume events appear on `rdData` and `rootHubReset` one cycle after the edge that samples them. `sofEnable` and `sofStarted` appear CYCLES_PER_MS cycles after the state first reads operational. `wakeReq` follows `resumeFlag` in the same cycle. The bench drives inputs just after a rising edge and compares every output with a behavioural model on every falling edge. That model advances its own count of cycles spent in operational, so each result is checked in the cycle it is due. Directed checks also count the cycles from entry into operational up to the rise of `sofEnable`, and compare that count with CYCLES_PER_MS.

// File: rtl/usb_hc_fstate_pkg.sv
package usb_hc_fstate_pkg;

  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } fsState_t;

  localparam int WORD_W    = 5;
  localparam int POS_ROUTE = 2;
  localparam int POS_WAKE  = 3;
  localparam int POS_CONN  = 4;

  typedef struct packed {
    logic swClear;
    logic wrCfg;
    logic nextOper;
    logic enterOper;
  } ctlStrobe_t;

endpackage

// File: rtl/usb_hc_fstate_ctrl.sv
module usb_hc_fstate_ctrl
  import usb_hc_fstate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       swReset,
  input  logic       wrEn,
  input  fsState_t   wrState,
  input  logic       portResume,
  output fsState_t   state,
  output ctlStrobe_t strobe
);

  fsState_t nextState;

  always_comb begin
    nextState = state;
    if (swReset) begin
      nextState = FS_SUSPEND;
    end else if (wrEn) begin
      nextState = wrState;
    end else if (state == FS_SUSPEND && portResume) begin
      nextState = FS_RESUME;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= FS_RESET;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    strobe.swClear   = swReset;
    strobe.wrCfg     = wrEn && !swReset;
    strobe.nextOper  = (nextState == FS_OPER);
    strobe.enterOper = (nextState == FS_OPER) && (state != FS_OPER);
  end

  // R3: software reset lands in suspend
  assert_swreset_suspend_R3: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> (state == FS_SUSPEND));

  // R4: outside suspend, the state only moves by a driver action
  assert_no_self_move_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && !wrEn && state != FS_SUSPEND) |=> $stable(state));

  // R4: resume signaling while suspended leads to resume
  assert_resume_entry_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!swReset && !wrEn && state == FS_SUSPEND && portResume) |=> (state == FS_RESUME));

endmodule

// File: rtl/usb_hc_fstate_dp.sv
module usb_hc_fstate_dp
  import usb_hc_fstate_pkg::*;
#(
  parameter int CYCLES_PER_MS = 48000
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  fsState_t   state,
  input  logic       wrRoute,
  input  logic       wrWake,
  input  logic       wrConn,
  input  logic       resumeFlag,
  output logic       routeBit,
  output logic       wakeEn,
  output logic       wakeConn,
  output logic       sofEnable,
  output logic       sofStarted,
  output logic       wakeReq,
  output logic       rootHubReset
);

  localparam int CNT_W = (CYCLES_PER_MS > 2) ? $clog2(CYCLES_PER_MS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES_PER_MS - 1);

  logic [CNT_W-1:0] delayCnt;

  // control bits: software reset clears all but the connected flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeBit <= 1'b0;
      wakeEn   <= 1'b0;
      wakeConn <= 1'b0;
    end else if (strobe.swClear) begin
      routeBit <= 1'b0;
      wakeEn   <= 1'b0;
    end else if (strobe.wrCfg) begin
      routeBit <= wrRoute;
      wakeEn   <= wrWake;
      wakeConn <= wrConn;
    end
  end

  // one-millisecond delay before frames start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      delayCnt   <= '0;
      sofEnable  <= 1'b0;
      sofStarted <= 1'b0;
    end else begin
      sofStarted <= 1'b0;
      if (!strobe.nextOper || strobe.enterOper) begin
        delayCnt  <= '0;
        sofEnable <= 1'b0;
      end else if (!sofEnable) begin
        if (delayCnt == CNT_LAST) begin
          sofEnable  <= 1'b1;
          sofStarted <= 1'b1;
        end else begin
          delayCnt <= delayCnt + 1'b1;
        end
      end
    end
  end

  assign wakeReq      = wakeEn & resumeFlag;
  assign rootHubReset = (state == FS_RESET);

  // R6: frames never enabled outside operational
  assert_sof_only_oper_R6: assert property (@(posedge clk) disable iff (!rstN)
    sofEnable |-> (state == FS_OPER));

  // R6: count stays inside its window
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    delayCnt <= CNT_LAST);

  // R7: the started pulse lasts one cycle and comes with enable
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    sofStarted |=> !sofStarted);

  assert_pulse_with_en_R7: assert property (@(posedge clk) disable iff (!rstN)
    sofStarted |-> sofEnable);

  // R3: connected flag survives a software reset
  assert_conn_kept_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swClear |=> $stable(wakeConn));

endmodule

// File: rtl/usb_hc_fstate.sv
module usb_hc_fstate
  import usb_hc_fstate_pkg::*;
#(
  parameter int CYCLES_PER_MS = 48000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReset,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              portResume,
  input  logic              resumeFlag,
  output logic [WORD_W-1:0] rdData,
  output logic              sofEnable,
  output logic              sofStarted,
  output logic              wakeReq,
  output logic              rootHubReset
);

  fsState_t   state;
  ctlStrobe_t strobe;
  logic       routeBit;
  logic       wakeEn;
  logic       wakeConn;

  usb_hc_fstate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .swReset    (swReset),
    .wrEn       (wrEn),
    .wrState    (fsState_t'(wrData[1:0])),
    .portResume (portResume),
    .state      (state),
    .strobe     (strobe)
  );

  usb_hc_fstate_dp #(
    .CYCLES_PER_MS (CYCLES_PER_MS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .state        (state),
    .wrRoute      (wrData[POS_ROUTE]),
    .wrWake       (wrData[POS_WAKE]),
    .wrConn       (wrData[POS_CONN]),
    .resumeFlag   (resumeFlag),
    .routeBit     (routeBit),
    .wakeEn       (wakeEn),
    .wakeConn     (wakeConn),
    .sofEnable    (sofEnable),
    .sofStarted   (sofStarted),
    .wakeReq      (wakeReq),
    .rootHubReset (rootHubReset)
  );

  assign rdData = {wakeConn, wakeEn, routeBit, state};

endmodule

// File: tb/usb_hc_fstate_bench.sv
module usb_hc_fstate_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NMS        = 10;
  localparam int WDOG       = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swReset = 1'b0;
  logic       wrEn = 1'b0;
  logic [4:0] wrData = '0;
  logic       portResume = 1'b0;
  logic       resumeFlag = 1'b0;
  logic [4:0] rdData;
  logic       sofEnable, sofStarted, wakeReq, rootHubReset;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  usb_hc_fstate #(.CYCLES_PER_MS(NMS)) u_usb_hc_fstate (
    .clk(clk), .rstN(rstN), .swReset(swReset), .wrEn(wrEn), .wrData(wrData),
    .portResume(portResume), .resumeFlag(resumeFlag), .rdData(rdData),
    .sofEnable(sofEnable), .sofStarted(sofStarted), .wakeReq(wakeReq),
    .rootHubReset(rootHubReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int mState = 0;
  bit mRoute = 0, mWake = 0, mConn = 0;
  int operCycles = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState <= 0; mRoute <= 0; mWake <= 0; mConn <= 0; operCycles <= 0;
    end else begin
      int ns;
      ns = mState;
      if (swReset) begin
        ns = 3; mRoute <= 0; mWake <= 0;
      end else if (wrEn) begin
        ns = int'(wrData[1:0]);
        mRoute <= wrData[2]; mWake <= wrData[3]; mConn <= wrData[4];
      end else if (mState == 3 && portResume) begin
        ns = 1;
      end
      if (ns == 2 && mState == 2) operCycles <= (operCycles > NMS) ? operCycles : operCycles + 1;
      else operCycles <= 0;
      mState <= ns;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 rdData", 32'(rdData), 32'({mConn, mWake, mRoute, 2'(mState)}));
      chk("R5/R6 sofEnable", 32'(sofEnable), 32'(mState == 2 && operCycles >= NMS));
      chk("R7 sofStarted", 32'(sofStarted), 32'(mState == 2 && operCycles == NMS));
      chk("R8 wakeReq", 32'(wakeReq), 32'(mWake & resumeFlag));
      chk("R9 rootHubReset", 32'(rootHubReset), 32'(mState == 0));
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] d);
    wrEn = 1'b1; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic countToSof(output int n);
    n = 0;
    while (!sofEnable && n < 4*NMS) begin
      step(); n++;
    end
  endtask

  initial begin
    int n;
    step(); step();
    // R1: values during reset
    chk("R1 rdData in reset", 32'(rdData), 32'h0);
    chk("R9 rootHubReset in reset", 32'(rootHubReset), 32'h1);
    rstN = 1'b1;
    step();
    chk("R1 rdData after reset", 32'(rdData), 32'h0);
    chk("R1 sofEnable after reset", 32'(sofEnable), 32'h0);

    // R2: full write, operational
    wr(5'b11110);
    chk("R2 readback", 32'(rdData), 32'h1E);
    chk("R9 no reset signaling", 32'(rootHubReset), 32'h0);
    countToSof(n);
    chk("R5 delay length", 32'(n), 32'(NMS));
    chk("R7 started pulse", 32'(sofStarted), 32'h1);
    step();
    chk("R7 pulse over", 32'(sofStarted), 32'h0);
    wr(5'b11110);
    chk("R5 rewrite keeps frames", 32'(sofEnable), 32'h1);

    // R8 / R10
    resumeFlag = 1'b1; #1;
    chk("R8 wake request", 32'(wakeReq), 32'h1);
    wr(5'b11010);
    chk("R10 route cleared, wake same", 32'(wakeReq), 32'h1);
    chk("R10 route cleared, frames same", 32'(sofEnable), 32'h1);
    wr(5'b10110);
    chk("R8 wake disabled", 32'(wakeReq), 32'h0);
    resumeFlag = 1'b0;

    // R4: resume signaling ignored when operational
    portResume = 1'b1; step(); portResume = 1'b0;
    chk("R4 ignored in operational", 32'(rdData[1:0]), 32'h2);

    // R6: leave operational
    wr(5'b10011);
    chk("R6 frames off in suspend", 32'(sofEnable), 32'h0);
    portResume = 1'b1; step(); portResume = 1'b0;
    chk("R4 suspend to resume", 32'(rdData[1:0]), 32'h1);

    // R6: abort the delay and restart it
    wr(5'b10010);
    repeat (4) step();
    wr(5'b10000);
    chk("R9 reset signaling", 32'(rootHubReset), 32'h1);
    chk("R6 no frames after abort", 32'(sofEnable), 32'h0);
    wr(5'b10010);
    countToSof(n);
    chk("R6 full delay again", 32'(n), 32'(NMS));

    // R3: software reset with a simultaneous write
    wr(5'b10110);
    swReset = 1'b1; wrEn = 1'b1; wrData = 5'b01110;
    step();
    swReset = 1'b0; wrEn = 1'b0;
    chk("R3 software reset word", 32'(rdData), 32'h13);
    chk("R3 frames off", 32'(sofEnable), 32'h0);

    // R4: write beats resume in suspend
    wrEn = 1'b1; wrData = 5'b10000; portResume = 1'b1;
    step();
    wrEn = 1'b0; portResume = 1'b0;
    chk("R4 write wins over resume", 32'(rdData[1:0]), 32'h0);

    // R1: hardware reset clears connected flag
    wr(5'b11010);
    rstN = 1'b0; step(); rstN = 1'b1; step();
    chk("R1 hardware reset clears all", 32'(rdData), 32'h0);
    repeat (3) step();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule